// File: doc/BRIEF.md
# Associative Page Translation Buffer

This block turns a virtual address into a physical address by looking up the page number in a small, fully associative store of recent translations. The page number is the upper part of the virtual address. It is compared against every valid entry at the same time. On a match, the stored frame number is placed above the untouched in-page offset to form the physical address. All lookup outputs are combinational in the cycle of the request.

Each entry also stores three access-permission flags. It also keeps two status flags that the hardware maintains: referenced and modified. These tell a replacement policy how an entry has been used. When the page number is not in the store, the block asks an external table walker for the translation. The walker later writes the page, frame and permissions back through the fill port. A single flush input empties the whole store.

Top module: `assoc_xlate_buf`

## Requirements
- R1: The page number is `req_vaddr[15:10]` and the offset is `req_vaddr[9:0]` (default widths). On a hit, `rsp_paddr` equals `{frame, offset}` with an 8-bit frame. When there is no hit, `rsp_paddr` is zero.
- R2: `rsp_hit` is high only when `req_valid` is high and a valid entry holds the requested page. When `req_valid` is high and no valid entry holds the page, `rsp_walk` is high and `rsp_hit` is low.
- R3: The permission field has bit 0 = read, bit 1 = write and bit 2 = execute. `req_kind` has 0 = read, 1 = write and 2 = execute; code 3 is never allowed. A hit whose kind is not allowed raises `rsp_fault` together with `rsp_hit`. Without a hit there is no fault.
- R4: On a hit, `rsp_ref` and `rsp_dirty` show the entry's stored flags as they were before the current access. A permitted hit sets the referenced flag from the next cycle on.
- R5: A permitted write hit also sets the modified flag.
- R6: A faulting access leaves the referenced and modified flags unchanged.
- R7: A fill of a page that is not present goes to the lowest-numbered invalid entry. The new entry's flags are cleared, and it is visible to the lookup in the next cycle.
- R8: When every entry is valid, a fill of a new page overwrites the entry chosen by a round-robin pointer. The pointer is 0 after reset and moves up by one, wrapping, each time it is used.
- R9: A fill whose page is already held by a valid entry rewrites that entry in place and clears its flags. The round-robin pointer does not move.
- R10: `flush` invalidates every entry in one cycle. It takes precedence over a fill and over flag updates in the same cycle.
- R11: After reset every entry is invalid, so every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 16 | Virtual address to translate |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 none |
| rsp_hit | output | 1 | A valid entry matches the page |
| rsp_walk | output | 1 | Miss: a table walk is needed |
| rsp_fault | output | 1 | Hit, but the access type is not permitted |
| rsp_paddr | output | 18 | Physical address: frame above offset |
| rsp_ref | output | 1 | Stored referenced flag of the hit entry |
| rsp_dirty | output | 1 | Stored modified flag of the hit entry |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_page | input | 6 | Page number of the fill |
| fill_frame | input | 8 | Frame number of the fill |
| fill_perm | input | 3 | Permissions of the fill: bit0 read, bit1 write, bit2 execute |

## Verification
Several properties hold in every cycle and are checked by assertions:
- no more than one entry matches a page;
- a hit keeps the request offset;
- a fault never appears without a hit, and kind 3 always faults;
- a flush empties the store by the next cycle;
- a fresh fill is visible with cleared flags;
- the referenced and modified flags stick after a permitted access and stay put after a faulting one.

Other behaviour is only visible across a sequence of scenarios run by the bench. This covers which entry a fill lands in, the order of round-robin eviction, rewriting an entry in place, and a flush that overrides a fill in the same cycle. These are checked against a model of the entry store.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_NONE  = 2'd3
   } acc_kind_e;

   // Packed so that read is bit 0, write bit 1, execute bit 2.
   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } perm_t;

endpackage

// File: rtl/xlb_access_guard.sv
module xlb_access_guard
   import xlb_pkg::*;
(
   input  perm_t       perm,
   input  logic [1:0]  kind,
   output logic        allow
);

   acc_kind_e kind_e;

   always_comb begin
      kind_e = acc_kind_e'(kind);
      unique case (kind_e)
         ACC_READ:  allow = perm.r;
         ACC_WRITE: allow = perm.w;
         ACC_EXEC:  allow = perm.x;
         default:   allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/xlb_entry_bank.sv
module xlb_entry_bank
   import xlb_pkg::*;
#(
   parameter  int DEPTH   = 64,
   parameter  int PAGE_W  = 6,
   parameter  int FRAME_W = 8,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [PAGE_W-1:0]  wr_page,
   input  logic [FRAME_W-1:0] wr_frame,
   input  perm_t              wr_perm,
   input  logic               upd_en,
   input  logic [IDX_W-1:0]   upd_idx,
   input  logic               upd_dirty,
   input  logic [PAGE_W-1:0]  lk_page,
   input  logic [PAGE_W-1:0]  fl_page,
   output logic [DEPTH-1:0]   lk_match,
   output logic [DEPTH-1:0]   fl_match,
   output logic [DEPTH-1:0]   valid_vec,
   output logic [IDX_W-1:0]   lk_idx,
   output logic [FRAME_W-1:0] lk_frame,
   output perm_t              lk_perm,
   output logic               lk_ref,
   output logic               lk_mod
);

   logic [FRAME_W-1:0] frame_a [DEPTH];
   logic [2:0]         perm_a  [DEPTH];
   logic [DEPTH-1:0]   ref_vec;
   logic [DEPTH-1:0]   mod_vec;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);

      logic               vld_q;
      logic [PAGE_W-1:0]  page_q;
      logic [FRAME_W-1:0] frame_q;
      perm_t              perm_q;
      logic               ref_q;
      logic               mod_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q   <= 1'b0;
            page_q  <= '0;
            frame_q <= '0;
            perm_q  <= '0;
            ref_q   <= 1'b0;
            mod_q   <= 1'b0;
         end else if (flush) begin
            vld_q <= 1'b0;
         end else if (wr_en && (wr_idx == MY_IDX)) begin
            vld_q   <= 1'b1;
            page_q  <= wr_page;
            frame_q <= wr_frame;
            perm_q  <= wr_perm;
            ref_q   <= 1'b0;
            mod_q   <= 1'b0;
         end else if (upd_en && (upd_idx == MY_IDX)) begin
            ref_q <= 1'b1;
            if (upd_dirty) begin
               mod_q <= 1'b1;
            end
         end
      end

      assign valid_vec[gi] = vld_q;
      assign lk_match[gi]  = vld_q && (page_q == lk_page);
      assign fl_match[gi]  = vld_q && (page_q == fl_page);
      assign frame_a[gi]   = frame_q;
      assign perm_a[gi]    = perm_q;
      assign ref_vec[gi]   = ref_q;
      assign mod_vec[gi]   = mod_q;
   end

   // At most one entry matches, so an OR over the gated fields selects it.
   logic [2:0] perm_or;

   always_comb begin
      lk_idx   = '0;
      lk_frame = '0;
      perm_or  = '0;
      lk_ref   = 1'b0;
      lk_mod   = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (lk_match[i]) begin
            lk_idx   = lk_idx | IDX_W'(i);
            lk_frame = lk_frame | frame_a[i];
            perm_or  = perm_or | perm_a[i];
            lk_ref   = lk_ref | ref_vec[i];
            lk_mod   = lk_mod | mod_vec[i];
         end
      end
      lk_perm = perm_t'(perm_or);
   end

endmodule

// File: rtl/xlb_victim_pick.sv
module xlb_victim_pick #(
   parameter  int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             fill_valid,
   input  logic [DEPTH-1:0] valid_vec,
   input  logic [DEPTH-1:0] fl_match,
   output logic [IDX_W-1:0] pick_idx
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] match_idx;
   logic [IDX_W-1:0] free_idx;
   logic             any_match;
   logic             any_free;

   always_comb begin
      match_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (fl_match[i]) begin
            match_idx = match_idx | IDX_W'(i);
         end
      end
      any_match = |fl_match;
   end

   // Walk downwards so the lowest free index is the one that remains.
   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
      end
   end

   always_comb begin
      if (any_match) begin
         pick_idx = match_idx;
      end else if (any_free) begin
         pick_idx = free_idx;
      end else begin
         pick_idx = rr_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (fill_valid && !flush && !any_match && !any_free) begin
         rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/assoc_xlate_buf.sv
module assoc_xlate_buf
   import xlb_pkg::*;
#(
   parameter  int VA_W    = 16,
   parameter  int OFS_W   = 10,
   parameter  int FRAME_W = 8,
   parameter  int DEPTH   = 64,
   localparam int PAGE_W  = VA_W - OFS_W,
   localparam int PA_W    = FRAME_W + OFS_W,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_kind,
   output logic               rsp_hit,
   output logic               rsp_walk,
   output logic               rsp_fault,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic               rsp_ref,
   output logic               rsp_dirty,
   input  logic               fill_valid,
   input  logic [PAGE_W-1:0]  fill_page,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic [2:0]         fill_perm
);

   if (OFS_W < 1 || OFS_W >= VA_W) begin : g_bad_split
      $error("assoc_xlate_buf: OFS_W must lie between 1 and VA_W-1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("assoc_xlate_buf: DEPTH must be at least 2");
   end
   if (FRAME_W < 1) begin : g_bad_frame
      $error("assoc_xlate_buf: FRAME_W must be positive");
   end

   logic [PAGE_W-1:0]  lk_page;
   logic [OFS_W-1:0]   lk_ofs;
   logic [DEPTH-1:0]   lk_match;
   logic [DEPTH-1:0]   fl_match;
   logic [DEPTH-1:0]   valid_vec;
   logic [IDX_W-1:0]   lk_idx;
   logic [IDX_W-1:0]   pick_idx;
   logic [FRAME_W-1:0] lk_frame;
   perm_t              lk_perm;
   logic               lk_ref;
   logic               lk_mod;
   logic               allow;
   logic               hit;
   logic               upd_en;

   assign lk_page = req_vaddr[VA_W-1:OFS_W];
   assign lk_ofs  = req_vaddr[OFS_W-1:0];

   xlb_entry_bank #(
      .DEPTH   (DEPTH),
      .PAGE_W  (PAGE_W),
      .FRAME_W (FRAME_W)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (fill_valid),
      .wr_idx    (pick_idx),
      .wr_page   (fill_page),
      .wr_frame  (fill_frame),
      .wr_perm   (perm_t'(fill_perm)),
      .upd_en    (upd_en),
      .upd_idx   (lk_idx),
      .upd_dirty (req_kind == ACC_WRITE),
      .lk_page   (lk_page),
      .fl_page   (fill_page),
      .lk_match  (lk_match),
      .fl_match  (fl_match),
      .valid_vec (valid_vec),
      .lk_idx    (lk_idx),
      .lk_frame  (lk_frame),
      .lk_perm   (lk_perm),
      .lk_ref    (lk_ref),
      .lk_mod    (lk_mod)
   );

   xlb_victim_pick #(
      .DEPTH (DEPTH)
   ) victim_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .fill_valid (fill_valid),
      .valid_vec  (valid_vec),
      .fl_match   (fl_match),
      .pick_idx   (pick_idx)
   );

   xlb_access_guard guard_i (
      .perm  (lk_perm),
      .kind  (req_kind),
      .allow (allow)
   );

   assign hit       = req_valid && (|lk_match);
   assign upd_en    = hit && allow;
   assign rsp_hit   = hit;
   assign rsp_walk  = req_valid && !(|lk_match);
   assign rsp_fault = hit && !allow;
   assign rsp_paddr = hit ? {lk_frame, lk_ofs} : '0;
   assign rsp_ref   = hit && lk_ref;
   assign rsp_dirty = hit && lk_mod;

endmodule

// File: rtl/xlb_checker.sv
module xlb_checker #(
   parameter int VA_W    = 16,
   parameter int OFS_W   = 10,
   parameter int FRAME_W = 8,
   parameter int DEPTH   = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     flush,
   input logic                     req_valid,
   input logic [VA_W-1:0]          req_vaddr,
   input logic [1:0]               req_kind,
   input logic                     fill_valid,
   input logic [VA_W-OFS_W-1:0]    fill_page,
   input logic                     rsp_hit,
   input logic                     rsp_walk,
   input logic                     rsp_fault,
   input logic [FRAME_W+OFS_W-1:0] rsp_paddr,
   input logic                     rsp_ref,
   input logic                     rsp_dirty,
   input logic [DEPTH-1:0]         match_vec
);

   assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   assert_walk_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_walk |-> (!rsp_hit && !rsp_fault && req_valid));

   assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_paddr[OFS_W-1:0] == req_vaddr[OFS_W-1:0]));

   assert_fault_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_hit);

   assert_kind_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && req_kind == 2'd3) |-> rsp_fault);

   assert_ref_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rsp_hit && !rsp_fault && !flush && !fill_valid) && req_valid &&
       req_vaddr == $past(req_vaddr)) |-> (rsp_hit && rsp_ref));

   assert_dirty_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rsp_hit && !rsp_fault && !flush && !fill_valid && req_kind == 2'd1) &&
       req_valid && req_vaddr == $past(req_vaddr)) |-> (rsp_hit && rsp_dirty));

   assert_fault_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rsp_fault && !flush && !fill_valid) && req_valid &&
       req_vaddr == $past(req_vaddr)) |->
      (rsp_hit && rsp_ref == $past(rsp_ref) && rsp_dirty == $past(rsp_dirty)));

   assert_fill_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fill_valid && !flush) && req_valid &&
       req_vaddr[VA_W-1:OFS_W] == $past(fill_page)) |->
      (rsp_hit && !rsp_ref && !rsp_dirty));

   assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !rsp_hit);

endmodule

bind assoc_xlate_buf xlb_checker #(
   .VA_W    (VA_W),
   .OFS_W   (OFS_W),
   .FRAME_W (FRAME_W),
   .DEPTH   (DEPTH)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .req_valid  (req_valid),
   .req_vaddr  (req_vaddr),
   .req_kind   (req_kind),
   .fill_valid (fill_valid),
   .fill_page  (fill_page),
   .rsp_hit    (rsp_hit),
   .rsp_walk   (rsp_walk),
   .rsp_fault  (rsp_fault),
   .rsp_paddr  (rsp_paddr),
   .rsp_ref    (rsp_ref),
   .rsp_dirty  (rsp_dirty),
   .match_vec  (lk_match)
);

// File: tb/assoc_xlate_buf_tb_top.sv
`timescale 1ns/1ps
module assoc_xlate_buf_tb_top;

   localparam int DEPTH = 16;
   localparam int WD_NS = 20 * 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        fill_valid = 1'b0;
   logic [5:0]  fill_page = '0;
   logic [7:0]  fill_frame = '0;
   logic [2:0]  fill_perm = '0;
   logic        rsp_hit, rsp_walk, rsp_fault, rsp_ref, rsp_dirty;
   logic [17:0] rsp_paddr;

   always #10 clk = ~clk;

   assoc_xlate_buf #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_vaddr(req_vaddr), .req_kind(req_kind), .rsp_hit(rsp_hit),
      .rsp_walk(rsp_walk), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
      .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty), .fill_valid(fill_valid),
      .fill_page(fill_page), .fill_frame(fill_frame), .fill_perm(fill_perm)
   );

   int checks = 0;
   int fails  = 0;

   // Model of the entry store, written from the requirements.
   bit         m_vld [DEPTH];
   logic [5:0] m_pg  [DEPTH];
   logic [7:0] m_fr  [DEPTH];
   logic [2:0] m_pm  [DEPTH];
   bit         m_rf  [DEPTH];
   bit         m_md  [DEPTH];
   int         m_rr;

   logic       o_hit, o_walk, o_fault, o_ref, o_dirty;
   logic [17:0] o_pa;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic int m_find(input logic [5:0] p);
      for (int i = 0; i < DEPTH; i++) begin
         if (m_vld[i] && m_pg[i] == p) return i;
      end
      return -1;
   endfunction

   function automatic bit m_allow(input int idx, input logic [1:0] k);
      if (k == 2'd3) return 1'b0;
      return m_pm[idx][k];
   endfunction

   task automatic m_reset();
      for (int i = 0; i < DEPTH; i++) begin
         m_vld[i] = 0; m_rf[i] = 0; m_md[i] = 0;
         m_pg[i] = '0; m_fr[i] = '0; m_pm[i] = '0;
      end
      m_rr = 0;
   endtask

   task automatic step(input bit fl, input bit rv, input logic [15:0] va, input logic [1:0] k,
                       input bit fv, input logic [5:0] fp, input logic [7:0] ff, input logic [2:0] fpm);
      int hi;
      int fi;
      bit e_hit, e_fault, e_rf, e_md;
      logic [17:0] e_pa;
      @(negedge clk);
      flush = fl; req_valid = rv; req_vaddr = va; req_kind = k;
      fill_valid = fv; fill_page = fp; fill_frame = ff; fill_perm = fpm;
      #2;
      hi      = rv ? m_find(va[15:10]) : -1;
      e_hit   = (hi >= 0);
      e_fault = e_hit && !m_allow(hi, k);
      e_pa    = e_hit ? {m_fr[hi], va[9:0]} : 18'd0;
      e_rf    = e_hit ? m_rf[hi] : 1'b0;
      e_md    = e_hit ? m_md[hi] : 1'b0;
      o_hit = rsp_hit; o_walk = rsp_walk; o_fault = rsp_fault;
      o_pa = rsp_paddr; o_ref = rsp_ref; o_dirty = rsp_dirty;
      chk(o_hit == e_hit, "R2 hit", 32'(o_hit), 32'(e_hit));
      chk(o_walk == (rv && !e_hit), "R2 walk", 32'(o_walk), 32'(rv && !e_hit));
      chk(o_fault == e_fault, "R3 fault", 32'(o_fault), 32'(e_fault));
      chk(o_pa == e_pa, "R1 paddr", 32'(o_pa), 32'(e_pa));
      chk(o_ref == e_rf, "R4 ref", 32'(o_ref), 32'(e_rf));
      chk(o_dirty == e_md, "R5 dirty", 32'(o_dirty), 32'(e_md));
      @(posedge clk);
      #1;
      if (fl) begin
         for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
      end else begin
         fi = -1;
         if (fv) begin
            fi = m_find(fp);
            if (fi < 0) begin
               for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) fi = i;
            end
            if (fi < 0) begin
               fi = m_rr;
               m_rr = (m_rr + 1) % DEPTH;
            end
            m_vld[fi] = 1; m_pg[fi] = fp; m_fr[fi] = ff; m_pm[fi] = fpm;
            m_rf[fi] = 0; m_md[fi] = 0;
         end
         if (e_hit && !e_fault && hi != fi) begin
            m_rf[hi] = 1;
            if (k == 2'd1) m_md[hi] = 1;
         end
      end
      flush = 0; req_valid = 0; fill_valid = 0;
   endtask

   task automatic look(input logic [5:0] p, input logic [9:0] o, input logic [1:0] k);
      step(0, 1, {p, o}, k, 0, '0, '0, '0);
   endtask

   task automatic fill(input logic [5:0] p, input logic [7:0] f, input logic [2:0] pm);
      step(0, 0, '0, 2'd0, 1, p, f, pm);
   endtask

   initial begin
      #WD_NS;
      fails++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: empty after reset
      look(6'd3, 10'h00, 2'd0);
      chk(o_walk == 1 && o_hit == 0, "R11 reset miss", 32'(o_hit), 32'd0);

      // Read-only page: write faults, flags untouched (R6), then read sets ref (R4)
      fill(6'd5, 8'h3C, 3'b001);
      look(6'd5, 10'h155, 2'd1);
      chk(o_fault == 1, "R3 write on read-only", 32'(o_fault), 32'd1);
      look(6'd5, 10'h155, 2'd0);
      chk(o_pa == {8'h3C, 10'h155}, "R1 paddr", 32'(o_pa), 32'({8'h3C, 10'h155}));
      chk(o_ref == 0, "R6 ref kept after fault", 32'(o_ref), 32'd0);
      look(6'd5, 10'h001, 2'd0);
      chk(o_ref == 1, "R4 ref set", 32'(o_ref), 32'd1);

      // R5: write sets modified
      fill(6'd7, 8'h11, 3'b011);
      look(6'd7, 10'h3FF, 2'd1);
      look(6'd7, 10'h000, 2'd0);
      chk(o_dirty == 1, "R5 dirty set", 32'(o_dirty), 32'd1);
      look(6'd7, 10'h000, 2'd3);
      chk(o_fault == 1, "R3 kind none", 32'(o_fault), 32'd1);
      look(6'd7, 10'h000, 2'd2);
      chk(o_fault == 1, "R3 exec denied", 32'(o_fault), 32'd1);

      // R9: refill same page in place
      fill(6'd5, 8'h22, 3'b111);
      look(6'd5, 10'h010, 2'd2);
      chk(o_pa[17:10] == 8'h22 && o_ref == 0 && o_fault == 0, "R9 in-place rewrite",
          32'(o_pa[17:10]), 32'h22);

      // R10: flush beats a fill in the same cycle
      step(1, 0, '0, 2'd0, 1, 6'd9, 8'h99, 3'b111);
      look(6'd9, 10'h0, 2'd0);
      chk(o_hit == 0, "R10 flush over fill", 32'(o_hit), 32'd0);
      look(6'd7, 10'h0, 2'd0);
      chk(o_hit == 0, "R10 flush empties", 32'(o_hit), 32'd0);

      // R7: fill into empty store, visible with clear flags
      for (int p = 20; p < 20 + DEPTH; p++) fill(6'(p), 8'(p), 3'b111);
      look(6'd35, 10'h0, 2'd0);
      chk(o_hit == 1 && o_ref == 0, "R7 fill visible", 32'(o_hit), 32'd1);

      // R8: round-robin eviction starting at entry 0
      fill(6'd40, 8'h40, 3'b111);
      look(6'd20, 10'h0, 2'd0);
      chk(o_hit == 0, "R8 first victim", 32'(o_hit), 32'd0);
      look(6'd21, 10'h0, 2'd0);
      chk(o_hit == 1, "R8 neighbour kept", 32'(o_hit), 32'd1);
      fill(6'd41, 8'h41, 3'b111);
      look(6'd21, 10'h0, 2'd0);
      chk(o_hit == 0, "R8 second victim", 32'(o_hit), 32'd0);
      look(6'd40, 10'h0, 2'd0);
      chk(o_hit == 1, "R8 new entry", 32'(o_hit), 32'd1);

      // Random mix against the model
      for (int n = 0; n < 4000; n++) begin
         bit fl, rv, fv;
         fl = ($urandom % 200) == 0;
         rv = ($urandom % 4) != 0;
         fv = ($urandom % 4) == 0;
         step(fl, rv, 16'($urandom), 2'($urandom), fv, 6'($urandom % 40),
              8'($urandom), 3'($urandom));
      end

      summary();
      $finish;
   end

endmodule